// File: doc/BRIEF.md
# Energy-Efficient Ethernet Transmit Low-Power-Idle Controller

This block decides when an Ethernet MAC transmitter stops sending normal idle and starts signalling low-power idle to the link partner, and when it comes back. It holds a single 32-bit control and status word that software reads and writes. The word carries four control bits, two live state bits and four event flags. The flags latch transmit entry, transmit exit, receive entry and receive exit, and a read clears them.

Software can drive the transmitter directly with the enable bit. It can also set the automatic mode. In that mode entry waits until the MAC core and the application side have nothing left to send. Any new frame or a transmit FIFO flush then wakes the transmitter and clears the enable bit. Entry is also gated by a link-stable timer. The transmitter may only signal low-power idle after the effective link has been up for a programmed number of clock cycles without a break. Leaving the state costs a programmed wake period, and the exit flag is raised only when that period ends. The receive side is observed through a synchronised pattern-detect input.

Top module: `eee_tx_lpi_ctrl`

## Requirements
- R1: After reset the read word is 0 and the outputs tx_lpi_assert, tx_wake_active and rx_lpi_active are 0.
- R2: Bits 19 (auto mode), 18 (interface link-status select, writable only when HAS_IF_LINK is 1), 17 (link-up) and 16 (enable) are written from csr_wdata and read back. Bit 9 is the live receive state and bit 8 the live transmit state. Bits 3..0 are the flags. Every other bit reads 0.
- R3: With bit 19 at 0, bit 16 at 1 and the link stable, tx_lpi_assert rises one cycle later and flag bit 0 is set. The pending inputs have no effect in this mode.
- R4: Clearing bit 16 while in the low-power state drops tx_lpi_assert on the next cycle and holds tx_wake_active for TW_CYCLES cycles. When the wake period ends, tx_wake_active falls and flag bit 1 is set. Bit 16 is not cleared by hardware in manual mode.
- R5: With bits 19 and 16 both at 1, no entry occurs while core_tx_busy, app_tx_pending or tx_new_frame is 1. Entry follows one cycle after all three are 0.
- R6: In automatic mode, a tx_new_frame pulse during the low-power state starts the wake period on the next cycle and clears bit 16.
- R7: In automatic mode, a tx_fifo_flush pulse does the same as R6. With bit 19 at 0, neither tx_new_frame nor tx_fifo_flush affects the low-power state.
- R8: tx_lpi_assert is 1 only while the effective link has been up for at least LS_CYCLES consecutive cycles. A drop restarts the count. A drop during the low-power state clears tx_lpi_assert at once and starts the wake period on the next cycle.
- R9: The effective link is bit 17 AND if_link_up when bit 18 is 1, and bit 17 alone when bit 18 is 0.
- R10: Bit 9 and rx_lpi_active follow rx_lpi_detect after SYNC_STAGES cycles. One cycle after bit 9 rises, flag bit 2 is set. One cycle after it falls, flag bit 3 is set.
- R11: A cycle with csr_rd_en at 1 returns the current word and clears flag bits 3..0 at the clock edge. Control and live bits are unchanged.
- R12: A flag whose set event falls in the same cycle as a clearing read ends that cycle set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_wr_en | input | 1 | Write strobe for the control word |
| csr_rd_en | input | 1 | Read strobe; clears the flags at the edge |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Current control and status word |
| if_link_up | input | 1 | Link status derived from the PHY interface |
| core_tx_busy | input | 1 | Frames still outstanding inside the MAC core |
| app_tx_pending | input | 1 | Frames queued on the application side |
| tx_new_frame | input | 1 | New frame submitted for transmission |
| tx_fifo_flush | input | 1 | Transmit FIFO flush command |
| rx_lpi_detect | input | 1 | Receive datapath sees the low-power-idle pattern |
| tx_lpi_assert | output | 1 | Transmit datapath must send the low-power-idle pattern |
| tx_wake_active | output | 1 | Wake period in progress |
| rx_lpi_active | output | 1 | Synchronised receive low-power state |

## Verification
The bench builds the block with LS_CYCLES 5, TW_CYCLES 3, SYNC_STAGES 2 and HAS_IF_LINK 1. These short timers make every entry edge, wake length and link-restart point a cycle-exact check. With the interface select present, all eight combinations of select, link-up bit and interface link can be swept, as can all eight combinations of the three pending sources in automatic mode. The two-stage synchroniser makes it possible to line up a receive flag event with a clearing read in the same cycle.

// File: rtl/eee_lpi_pkg.sv
package eee_lpi_pkg;

  typedef enum logic [1:0] {
    TXS_ACTIVE = 2'd0,
    TXS_LPI    = 2'd1,
    TXS_WAKE   = 2'd2
  } tx_state_e;

  localparam int BIT_AUTO     = 19;
  localparam int BIT_IFLS_EN  = 18;
  localparam int BIT_LINK     = 17;
  localparam int BIT_EN       = 16;
  localparam int BIT_RX_LIVE  = 9;
  localparam int BIT_TX_LIVE  = 8;
  localparam int NUM_FLAGS    = 4;
  localparam int FLG_TX_ENTRY = 0;
  localparam int FLG_TX_EXIT  = 1;
  localparam int FLG_RX_ENTRY = 2;
  localparam int FLG_RX_EXIT  = 3;

  typedef struct packed {
    logic auto_mode;
    logic ifls_en;
    logic link_up;
    logic lpi_en;
  } lpi_ctrl_t;

  function automatic int cnt_width(int limit);
    return (limit < 1) ? 1 : $clog2(limit + 1);
  endfunction

  function automatic logic eff_link(logic pls, logic ifls_en, logic if_link);
    return pls & (if_link | ~ifls_en);
  endfunction

  function automatic logic entry_allowed(logic en, logic auto_m, logic busy, logic stable);
    return en & stable & ~(auto_m & busy);
  endfunction

  function automatic logic wake_request(logic en, logic auto_m, logic stable, logic wake_evt);
    return ~en | ~stable | (auto_m & wake_evt);
  endfunction

  function automatic logic [31:0] pack_word(lpi_ctrl_t c, logic tx_live, logic rx_live,
                                            logic [NUM_FLAGS-1:0] flags);
    logic [31:0] w;
    w = '0;
    w[BIT_AUTO]    = c.auto_mode;
    w[BIT_IFLS_EN] = c.ifls_en;
    w[BIT_LINK]    = c.link_up;
    w[BIT_EN]      = c.lpi_en;
    w[BIT_RX_LIVE] = rx_live;
    w[BIT_TX_LIVE] = tx_live;
    w[NUM_FLAGS-1:0] = flags;
    return w;
  endfunction

endpackage

// File: rtl/eee_lpi_link_timer.sv
module eee_lpi_link_timer
  import eee_lpi_pkg::*;
#(
  parameter int LS_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link_ok,
  output logic link_stable
);

  localparam int W = cnt_width(LS_CYCLES);
  localparam logic [W-1:0] LS_LIM = W'(LS_CYCLES);

  logic [W-1:0] up_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_cnt <= '0;
    end else if (!link_ok) begin
      up_cnt <= '0;
    end else if (up_cnt != LS_LIM) begin
      up_cnt <= up_cnt + 1'b1;
    end
  end

  assign link_stable = link_ok && (up_cnt == LS_LIM);

endmodule

// File: rtl/eee_lpi_tx_fsm.sv
module eee_lpi_tx_fsm
  import eee_lpi_pkg::*;
#(
  parameter int TW_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lpi_en,
  input  logic auto_mode,
  input  logic pending_any,
  input  logic wake_evt,
  input  logic link_stable,
  output logic lpi_assert,
  output logic waking,
  output logic entry_evt,
  output logic exit_evt,
  output logic auto_clr
);

  localparam int W = cnt_width(TW_CYCLES);
  localparam logic [W-1:0] TW_LOAD = W'(TW_CYCLES);
  localparam logic [W-1:0] ONE     = W'(1);

  tx_state_e    state_q, state_d;
  logic [W-1:0] wake_cnt;
  logic         leave_lpi;

  assign entry_evt = (state_q == TXS_ACTIVE) &&
                     entry_allowed(lpi_en, auto_mode, pending_any, link_stable);
  assign leave_lpi = (state_q == TXS_LPI) &&
                     wake_request(lpi_en, auto_mode, link_stable, wake_evt);
  assign auto_clr  = (state_q == TXS_LPI) && auto_mode && wake_evt;
  assign exit_evt  = (state_q == TXS_WAKE) && (wake_cnt <= ONE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      TXS_ACTIVE: if (entry_evt) state_d = TXS_LPI;
      TXS_LPI:    if (leave_lpi) state_d = TXS_WAKE;
      TXS_WAKE:   if (exit_evt)  state_d = TXS_ACTIVE;
      default:    state_d = TXS_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= TXS_ACTIVE;
      wake_cnt <= '0;
    end else begin
      state_q <= state_d;
      if (leave_lpi) begin
        wake_cnt <= TW_LOAD;
      end else if (state_q == TXS_WAKE && !exit_evt) begin
        wake_cnt <= wake_cnt - 1'b1;
      end
    end
  end

  assign lpi_assert = (state_q == TXS_LPI) && link_stable;
  assign waking     = (state_q == TXS_WAKE);

endmodule

// File: rtl/eee_lpi_rx_mon.sv
module eee_lpi_rx_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_pattern,
  output logic rx_live,
  output logic rx_entry_evt,
  output logic rx_exit_evt
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   live_prev;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= rx_pattern;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[s] <= 1'b0;
        else        sync_q[s] <= sync_q[s-1];
      end
    end
  end

  assign rx_live = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_prev <= 1'b0;
    else        live_prev <= rx_live;
  end

  assign rx_entry_evt = rx_live & ~live_prev;
  assign rx_exit_evt  = ~rx_live & live_prev;

endmodule

// File: rtl/eee_lpi_csr.sv
module eee_lpi_csr
  import eee_lpi_pkg::*;
#(
  parameter bit HAS_IF_LINK = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [31:0]          wdata,
  input  logic                 auto_clr,
  input  logic                 tx_live,
  input  logic                 rx_live,
  input  logic [NUM_FLAGS-1:0] flag_set,
  output lpi_ctrl_t            ctrl,
  output logic [31:0]          rdata
);

  logic                 auto_q, link_q, en_q, ifls_q;
  logic [NUM_FLAGS-1:0] flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auto_q <= 1'b0;
      link_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      if (wr_en) begin
        auto_q <= wdata[BIT_AUTO];
        link_q <= wdata[BIT_LINK];
      end
      if (auto_clr)   en_q <= 1'b0;
      else if (wr_en) en_q <= wdata[BIT_EN];
    end
  end

  if (HAS_IF_LINK) begin : g_ifls
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ifls_q <= 1'b0;
      else if (wr_en) ifls_q <= wdata[BIT_IFLS_EN];
    end
  end else begin : g_no_ifls
    assign ifls_q = 1'b0;
  end

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           flag_q[f] <= 1'b0;
      else if (flag_set[f]) flag_q[f] <= 1'b1;
      else if (rd_en)       flag_q[f] <= 1'b0;
    end
  end

  assign ctrl  = '{auto_mode: auto_q, ifls_en: ifls_q, link_up: link_q, lpi_en: en_q};
  assign rdata = pack_word(ctrl, tx_live, rx_live, flag_q);

endmodule

// File: rtl/eee_tx_lpi_ctrl.sv
module eee_tx_lpi_ctrl
  import eee_lpi_pkg::*;
#(
  parameter int LS_CYCLES   = 16,
  parameter int TW_CYCLES   = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit HAS_IF_LINK = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_wr_en,
  input  logic        csr_rd_en,
  input  logic [31:0] csr_wdata,
  output logic [31:0] csr_rdata,
  input  logic        if_link_up,
  input  logic        core_tx_busy,
  input  logic        app_tx_pending,
  input  logic        tx_new_frame,
  input  logic        tx_fifo_flush,
  input  logic        rx_lpi_detect,
  output logic        tx_lpi_assert,
  output logic        tx_wake_active,
  output logic        rx_lpi_active
);

  lpi_ctrl_t            ctrl;
  logic                 link_ok, link_stable;
  logic                 pending_any, wake_evt;
  logic                 tx_entry_evt, tx_exit_evt, auto_clr;
  logic                 rx_live, rx_entry_evt, rx_exit_evt;
  logic [NUM_FLAGS-1:0] flag_set;

  assign link_ok     = eff_link(ctrl.link_up, ctrl.ifls_en, if_link_up);
  assign pending_any = core_tx_busy | app_tx_pending | tx_new_frame;
  assign wake_evt    = tx_new_frame | tx_fifo_flush;

  eee_lpi_link_timer #(.LS_CYCLES(LS_CYCLES)) u_link_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .link_ok     (link_ok),
    .link_stable (link_stable)
  );

  eee_lpi_tx_fsm #(.TW_CYCLES(TW_CYCLES)) u_tx_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .lpi_en      (ctrl.lpi_en),
    .auto_mode   (ctrl.auto_mode),
    .pending_any (pending_any),
    .wake_evt    (wake_evt),
    .link_stable (link_stable),
    .lpi_assert  (tx_lpi_assert),
    .waking      (tx_wake_active),
    .entry_evt   (tx_entry_evt),
    .exit_evt    (tx_exit_evt),
    .auto_clr    (auto_clr)
  );

  eee_lpi_rx_mon #(.SYNC_STAGES(SYNC_STAGES)) u_rx_mon (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_pattern   (rx_lpi_detect),
    .rx_live      (rx_live),
    .rx_entry_evt (rx_entry_evt),
    .rx_exit_evt  (rx_exit_evt)
  );

  always_comb begin
    flag_set               = '0;
    flag_set[FLG_TX_ENTRY] = tx_entry_evt;
    flag_set[FLG_TX_EXIT]  = tx_exit_evt;
    flag_set[FLG_RX_ENTRY] = rx_entry_evt;
    flag_set[FLG_RX_EXIT]  = rx_exit_evt;
  end

  eee_lpi_csr #(.HAS_IF_LINK(HAS_IF_LINK)) u_csr (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (csr_wr_en),
    .rd_en    (csr_rd_en),
    .wdata    (csr_wdata),
    .auto_clr (auto_clr),
    .tx_live  (tx_lpi_assert),
    .rx_live  (rx_live),
    .flag_set (flag_set),
    .ctrl     (ctrl),
    .rdata    (csr_rdata)
  );

  assign rx_lpi_active = rx_live;

endmodule

// File: rtl/eee_tx_lpi_ctrl_chk.sv
module eee_tx_lpi_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        csr_rd_en,
  input logic [31:0] csr_rdata,
  input logic        tx_new_frame,
  input logic        tx_fifo_flush,
  input logic        tx_lpi_assert,
  input logic        tx_wake_active,
  input logic        pending_any,
  input logic        tx_entry_evt,
  input logic        rx_entry_evt
);

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rdata[31:20] == 12'd0) && (csr_rdata[15:10] == 6'd0) && (csr_rdata[7:4] == 4'd0)); // R2

  AST_ENTRY_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_lpi_assert) |-> csr_rdata[0]); // R3

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_lpi_assert && tx_wake_active)); // R4

  AST_EXIT_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_wake_active) |-> csr_rdata[1]); // R4

  AST_AUTO_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_lpi_assert) && $past(csr_rdata[19])) |-> !$past(pending_any)); // R5

  AST_AUTO_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_lpi_assert && csr_rdata[19] && (tx_new_frame || tx_fifo_flush))
      |=> (tx_wake_active && !csr_rdata[16])); // R6

  AST_LPI_NEEDS_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    tx_lpi_assert |-> csr_rdata[17]); // R8

  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rd_en && !tx_entry_evt) |=> !csr_rdata[0]); // R11

  AST_SET_WINS_TX: assert property (@(posedge clk) disable iff (!rst_n)
    tx_entry_evt |=> csr_rdata[0]); // R12

  AST_SET_WINS_RX: assert property (@(posedge clk) disable iff (!rst_n)
    rx_entry_evt |=> csr_rdata[2]); // R12

endmodule

bind eee_tx_lpi_ctrl eee_tx_lpi_ctrl_chk chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .csr_rd_en      (csr_rd_en),
  .csr_rdata      (csr_rdata),
  .tx_new_frame   (tx_new_frame),
  .tx_fifo_flush  (tx_fifo_flush),
  .tx_lpi_assert  (tx_lpi_assert),
  .tx_wake_active (tx_wake_active),
  .pending_any    (pending_any),
  .tx_entry_evt   (tx_entry_evt),
  .rx_entry_evt   (rx_entry_evt)
);

// File: tb/eee_tx_lpi_ctrl_tb_top.sv
module eee_tx_lpi_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int LS = 5;
  localparam int TW = 3;
  localparam int SY = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_wr_en = 1'b0, csr_rd_en = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        if_link_up = 1'b0, core_tx_busy = 1'b0, app_tx_pending = 1'b0;
  logic        tx_new_frame = 1'b0, tx_fifo_flush = 1'b0, rx_lpi_detect = 1'b0;
  logic        tx_lpi_assert, tx_wake_active, rx_lpi_active;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eee_tx_lpi_ctrl #(.LS_CYCLES(LS), .TW_CYCLES(TW), .SYNC_STAGES(SY), .HAS_IF_LINK(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .csr_wr_en(csr_wr_en), .csr_rd_en(csr_rd_en),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .if_link_up(if_link_up),
    .core_tx_busy(core_tx_busy), .app_tx_pending(app_tx_pending),
    .tx_new_frame(tx_new_frame), .tx_fifo_flush(tx_fifo_flush),
    .rx_lpi_detect(rx_lpi_detect), .tx_lpi_assert(tx_lpi_assert),
    .tx_wake_active(tx_wake_active), .rx_lpi_active(rx_lpi_active)
  );

  function automatic logic [31:0] ctl(bit am, bit ifs, bit pls, bit en);
    return (32'(am) << 19) | (32'(ifs) << 18) | (32'(pls) << 17) | (32'(en) << 16);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [31:0] v);
    csr_wdata = v;
    csr_wr_en = 1'b1;
    tick(1);
    csr_wr_en = 1'b0;
  endtask

  task automatic rd(output logic [31:0] v);
    csr_rd_en = 1'b1;
    v = csr_rdata;
    tick(1);
    csr_rd_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    tick(2);
    // R1: reset state
    chk("R1 word", csr_rdata, 32'h0);
    chk("R1 outs", {29'd0, tx_lpi_assert, tx_wake_active, rx_lpi_active}, 32'h0);
    rst_n = 1'b1;
    tick(1);

    // R2: writable field readback, reserved bits zero
    wr(32'hFFFF_FFFF);
    chk("R2 readback", csr_rdata, 32'h000F_0000);
    wr(32'h0);
    rd(v);

    // R3 / R8: manual entry timing from link-up, pending ignored
    core_tx_busy = 1'b1; app_tx_pending = 1'b1;
    wr(ctl(0, 0, 1, 1));
    tick(LS);
    chk("R8 before stable", 32'(tx_lpi_assert), 32'h0);
    tick(1);
    chk("R3 entry", 32'(tx_lpi_assert), 32'h1);
    chk("R3 word", csr_rdata, ctl(0, 0, 1, 1) | 32'h101);
    core_tx_busy = 1'b0; app_tx_pending = 1'b0;

    // R4: manual exit and wake period
    wr(ctl(0, 0, 1, 0));
    tick(1);
    chk("R4 assert off", 32'(tx_lpi_assert), 32'h0);
    chk("R4 waking", 32'(tx_wake_active), 32'h1);
    tick(TW - 1);
    chk("R4 wake still", 32'(tx_wake_active), 32'h1);
    tick(1);
    chk("R4 wake done", 32'(tx_wake_active), 32'h0);
    rd(v);
    chk("R11 read value", v, ctl(0, 0, 1, 0) | 32'h3);
    chk("R11 cleared", csr_rdata, ctl(0, 0, 1, 0));

    // R5: automatic deferral over all pending combinations
    for (int p = 0; p < 8; p++) begin
      core_tx_busy = p[0]; app_tx_pending = p[1]; tx_new_frame = p[2];
      wr(ctl(1, 0, 1, 1));
      tick(3);
      chk($sformatf("R5 defer p=%0d", p), 32'(tx_lpi_assert), 32'(p == 0));
      if (p != 0) begin
        core_tx_busy = 1'b0; app_tx_pending = 1'b0; tx_new_frame = 1'b0;
        tick(1);
        chk($sformatf("R5 release p=%0d", p), 32'(tx_lpi_assert), 32'h1);
      end
      wr(ctl(1, 0, 1, 0));
      tick(TW + 2);
      rd(v);
    end

    // R6: wake on new frame in automatic mode
    wr(ctl(1, 0, 1, 1));
    tick(2);
    chk("R6 entered", 32'(tx_lpi_assert), 32'h1);
    tx_new_frame = 1'b1;
    tick(1);
    tx_new_frame = 1'b0;
    chk("R6 woke", {30'd0, tx_lpi_assert, tx_wake_active}, 32'h1);
    chk("R6 en cleared", csr_rdata & 32'h000F_0000, ctl(1, 0, 1, 0));
    tick(TW + 1);
    rd(v);

    // R7: flush and new frame ignored in manual mode, flush wakes in automatic
    wr(ctl(0, 0, 1, 1));
    tick(2);
    tx_fifo_flush = 1'b1; tx_new_frame = 1'b1;
    tick(1);
    tx_fifo_flush = 1'b0; tx_new_frame = 1'b0;
    tick(1);
    chk("R7 manual ignores", {30'd0, tx_lpi_assert, tx_wake_active}, 32'h2);
    chk("R7 manual en kept", csr_rdata & 32'h000F_0000, ctl(0, 0, 1, 1));
    wr(ctl(1, 0, 1, 1));
    tx_fifo_flush = 1'b1;
    tick(1);
    tx_fifo_flush = 1'b0;
    chk("R7 flush woke", {30'd0, tx_lpi_assert, tx_wake_active}, 32'h1);
    chk("R7 en cleared", csr_rdata & 32'h000F_0000, ctl(1, 0, 1, 0));
    tick(TW + 1);
    rd(v);

    // R8: link break restarts the timer, link loss during LPI
    wr(ctl(0, 0, 0, 1));
    tick(LS + 2);
    chk("R8 link down", 32'(tx_lpi_assert), 32'h0);
    wr(ctl(0, 0, 1, 1));
    tick(2);
    wr(ctl(0, 0, 0, 1));
    wr(ctl(0, 0, 1, 1));
    tick(LS);
    chk("R8 restarted", 32'(tx_lpi_assert), 32'h0);
    tick(1);
    chk("R8 stable entry", 32'(tx_lpi_assert), 32'h1);
    wr(ctl(0, 0, 0, 1));
    chk("R8 drop gates", {30'd0, tx_lpi_assert, tx_wake_active}, 32'h0);
    tick(1);
    chk("R8 drop wakes", 32'(tx_wake_active), 32'h1);
    tick(TW + 1);
    wr(32'h0);
    rd(v);

    // R9: sweep of select, link-up bit and interface link
    for (int c = 0; c < 8; c++) begin
      bit ifs, pls, il, expl;
      ifs = c[0]; pls = c[1]; il = c[2];
      expl = pls & (il | ~ifs);
      if_link_up = il;
      wr(ctl(0, ifs, pls, 1));
      tick(LS + 1);
      chk($sformatf("R9 ifs=%0d pls=%0d il=%0d", ifs, pls, il), 32'(tx_lpi_assert), 32'(expl));
      wr(ctl(0, ifs, pls, 0));
      tick(TW + 2);
      rd(v);
    end
    if_link_up = 1'b0;
    wr(32'h0);
    rd(v);

    // R10 / R12: receive tracking, flag set during a clearing read
    rx_lpi_detect = 1'b1;
    tick(SY - 1);
    chk("R10 sync delay", csr_rdata & 32'h200, 32'h0);
    tick(1);
    chk("R10 live", {30'd0, csr_rdata[9], rx_lpi_active}, 32'h3);
    csr_rd_en = 1'b1;
    v = csr_rdata;
    tick(1);
    csr_rd_en = 1'b0;
    chk("R12 pre flag", v & 32'h4, 32'h0);
    chk("R12 set wins", csr_rdata & 32'h4, 32'h4);
    rd(v);
    chk("R10 entry flag", v & 32'h20F, 32'h204);
    chk("R11 live kept", csr_rdata & 32'h20F, 32'h200);
    rx_lpi_detect = 1'b0;
    tick(SY);
    chk("R10 live off", 32'(rx_lpi_active), 32'h0);
    tick(1);
    chk("R10 exit flag", csr_rdata & 32'hF, 32'h8);
    rd(v);
    chk("R11 final clear", csr_rdata, 32'h0);

    finish_run();
  end

endmodule